// File: doc/BRIEF.md
# Address Window Router

The router sits behind a cache and sends each outgoing request to one of two downstream master ports. Port 0 leads to the system interconnect. Port 1 leads to the memory controller. The choice depends on a programmable address window that has 1 MiB granularity. If the window is enabled and the request address lies at or above the window start and below the window end, the request goes to port 1. Every other request goes to port 0.

Two 32-bit configuration registers hold the window. Software accesses them over a simple register bus: a select, a write strobe, a 12-bit offset and a 32-bit write word. Read data is combinational. After reset the window is enabled and covers the range from 1 MiB up to 3 GiB, so the lowest megabyte does not reach memory. To put memory at address zero, software lowers the start field to zero.

The request path is a plain valid/ready pass-through. The route select is combinational. The address and payload go to both ports unchanged. Only the selected port sees valid, and the ready signal comes back from that port only.

Top module: `addr_window_router`

## Requirements
- R1: After reset, a read at offset 0xC00 returns 0x00100001 and a read at offset 0xC04 returns 0xC0000000.
- R2: The start register is at offset 0xC00. Bits [31:20] hold the window start and bit 0 is the enable flag (1 = enabled). Bits [19:1] ignore writes and read as zero.
- R3: The end register is at offset 0xC04. Bits [31:20] hold the window end. Bits [19:0] ignore writes and read as zero.
- R4: When enabled, an address with start <= addr[31:20] < end drives route_sel to 1 (memory port). Any other address drives route_sel to 0 (interconnect port). Address bits [19:0] play no part in the decision.
- R5: When the enable flag is 0, route_sel is 0 for every address.
- R6: When enabled and end <= start, no address matches and route_sel is 0.
- R7: A register write changes the routing of requests presented in the cycle after the write edge. A request presented in the write cycle itself still uses the old value.
- R8: Only the selected port sees req_valid; the other port's valid is 0. req_ready equals the selected port's ready. Address and payload reach both ports unchanged.
- R9: Reads at any other offset return zero. Writes there change no register.
- R10: With the start field at 0 and the window enabled, address 0x00000000 routes to the memory port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 1 | Register bus select |
| cfg_we | input | 1 | Write strobe (with cfg_sel) |
| cfg_addr | input | 12 | Register offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_addr |
| req_valid | input | 1 | Request valid from the cache |
| req_ready | output | 1 | Ready returned from the selected port |
| req_addr | input | 32 | Physical request address |
| req_data | input | DATA_W | Request payload |
| route_sel | output | 1 | 1 = memory port, 0 = interconnect port |
| m0_valid | output | 1 | Interconnect port valid |
| m0_ready | input | 1 | Interconnect port ready |
| m0_addr | output | 32 | Interconnect port address |
| m0_data | output | DATA_W | Interconnect port payload |
| m1_valid | output | 1 | Memory port valid |
| m1_ready | input | 1 | Memory port ready |
| m1_addr | output | 32 | Memory port address |
| m1_data | output | DATA_W | Memory port payload |

## Verification
Routing, pass-through and read data are combinational. They are due in the same cycle the inputs are driven, so the bench drives on the falling edge and samples shortly after, before the next rising edge. A register write needs exactly one rising edge to take effect. The bench therefore samples route_sel once before that edge, expecting the old routing, and once after it, expecting the new routing, and never samples across two edges. Every vector is applied with the register writes fully completed before the address is sampled.

// File: rtl/addr_window_router.sv
module addr_window_router #(
  parameter int          DATA_W    = 64,
  parameter logic [11:0] START_OFS = 12'hC00,
  parameter logic [11:0] END_OFS   = 12'hC04,
  parameter logic [11:0] START_RST = 12'h001,
  parameter logic [11:0] END_RST   = 12'hC00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              cfg_we,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              route_sel,
  output logic              m0_valid,
  input  logic              m0_ready,
  output logic [31:0]       m0_addr,
  output logic [DATA_W-1:0] m0_data,
  output logic              m1_valid,
  input  logic              m1_ready,
  output logic [31:0]       m1_addr,
  output logic [DATA_W-1:0] m1_data
);
  localparam int FLD_LSB = 20;
  localparam int FLD_W   = 32 - FLD_LSB;

  logic [FLD_W-1:0] lo_q, hi_q;
  logic             en_q;
  logic             wr_lo, wr_hi;
  logic [FLD_W-1:0] page;

  assign wr_lo = cfg_sel && cfg_we && (cfg_addr == START_OFS);
  assign wr_hi = cfg_sel && cfg_we && (cfg_addr == END_OFS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= START_RST;
      en_q <= 1'b1;
      hi_q <= END_RST;
    end else begin
      if (wr_lo) begin
        lo_q <= cfg_wdata[31:FLD_LSB];
        en_q <= cfg_wdata[0];
      end
      if (wr_hi) hi_q <= cfg_wdata[31:FLD_LSB];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == START_OFS)    cfg_rdata = {lo_q, {(FLD_LSB-1){1'b0}}, en_q};
    else if (cfg_addr == END_OFS) cfg_rdata = {hi_q, {FLD_LSB{1'b0}}};
  end

  assign page      = req_addr[31:FLD_LSB];
  assign route_sel = en_q && (page >= lo_q) && (page < hi_q);

  assign m0_valid  = req_valid && !route_sel;
  assign m1_valid  = req_valid &&  route_sel;
  assign req_ready = route_sel ? m1_ready : m0_ready;
  assign m0_addr   = req_addr;
  assign m1_addr   = req_addr;
  assign m0_data   = req_data;
  assign m1_data   = req_data;

  // R8
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m0_valid, m1_valid}) && (req_valid == (m0_valid || m1_valid)));

  // R5
  disabled_m0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !m1_valid);

  // R6
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q <= lo_q) |-> !route_sel);

  // R2
  start_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == START_OFS) |-> (cfg_rdata[FLD_LSB-1:1] == '0));

  // R3
  end_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == END_OFS) |-> (cfg_rdata[FLD_LSB-1:0] == '0));

  // R7
  start_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(cfg_wdata[31:FLD_LSB])) && (en_q == $past(cfg_wdata[0])));

  // R9
  other_ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo || wr_hi) |=> $stable(lo_q) && $stable(hi_q) && $stable(en_q));
endmodule

// File: tb/addr_window_router_tb.sv
module addr_window_router_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int NV = 15;

  // {start reg word, end reg word, address, expected route}
  localparam logic [96:0] VEC [NV] = '{
    {32'h00100001, 32'hC0000000, 32'h00000000, 1'b0},
    {32'h00100001, 32'hC0000000, 32'h000FFFFF, 1'b0},
    {32'h00100001, 32'hC0000000, 32'h00100000, 1'b1},
    {32'h00100001, 32'hC0000000, 32'hBFFFFFFF, 1'b1},
    {32'h00100001, 32'hC0000000, 32'hC0000000, 1'b0},
    {32'h00100001, 32'hC0000000, 32'hFFFFFFFF, 1'b0},
    {32'h00000001, 32'hC0000000, 32'h00000000, 1'b1},
    {32'h40000001, 32'h80000000, 32'h3FFFFFFF, 1'b0},
    {32'h40000001, 32'h80000000, 32'h40000000, 1'b1},
    {32'h40000001, 32'h80000000, 32'h7FFFFFFF, 1'b1},
    {32'h40000001, 32'h80000000, 32'h80000000, 1'b0},
    {32'h40000000, 32'h80000000, 32'h50000000, 1'b0},
    {32'h80000001, 32'h80000000, 32'h80000000, 1'b0},
    {32'h90000001, 32'h80000000, 32'h85000000, 1'b0},
    {32'h001FFFFF, 32'h002FFFFF, 32'h00100000, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_sel = 1'b0, cfg_we = 1'b0;
  logic [11:0]   cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0, req_ready;
  logic [31:0]   req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          route_sel;
  logic          m0_valid, m0_ready = 1'b0, m1_valid, m1_ready = 1'b0;
  logic [31:0]   m0_addr, m1_addr;
  logic [DW-1:0] m0_data, m1_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_window_router #(.DATA_W(DW)) u_dut (
    .clk, .rst_n, .cfg_sel, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .req_valid, .req_ready, .req_addr, .req_data, .route_sel,
    .m0_valid, .m0_ready, .m0_addr, .m0_data,
    .m1_valid, .m1_ready, .m1_addr, .m1_data
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(tag, cfg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd_chk("R1 start reset", 12'hC00, 32'h00100001);
    rd_chk("R1 end reset",   12'hC04, 32'hC0000000);

    // R2 and R3 reserved bits read zero
    wr(12'hC00, 32'hFFFFFFFF);
    rd_chk("R2 start rsvd", 12'hC00, 32'hFFF00001);
    wr(12'hC04, 32'hFFFFFFFF);
    rd_chk("R3 end rsvd", 12'hC04, 32'hFFF00000);

    // R9 other offsets
    wr(12'hC08, 32'h12345678);
    rd_chk("R9 unmapped read", 12'hC08, 32'h0);
    rd_chk("R9 start kept", 12'hC00, 32'hFFF00001);
    rd_chk("R9 end kept",   12'hC04, 32'hFFF00000);

    // Table: R4, R5, R6, R10
    for (int i = 0; i < NV; i++) begin
      wr(12'hC00, VEC[i][96:65]);
      wr(12'hC04, VEC[i][64:33]);
      @(negedge clk);
      req_addr = VEC[i][32:1];
      #1 chk($sformatf("R4 R5 R6 R10 vector %0d", i), 64'(route_sel), 64'(VEC[i][0]));
    end

    // R8 pass-through
    wr(12'hC00, 32'h00100001);
    wr(12'hC04, 32'hC0000000);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h00200010; req_data = 64'hA5A5_0000_1234_5678;
    m0_ready = 1'b1; m1_ready = 1'b0;
    #1;
    chk("R8 m1_valid", 64'(m1_valid), 64'd1);
    chk("R8 m0_valid", 64'(m0_valid), 64'd0);
    chk("R8 ready from m1", 64'(req_ready), 64'd0);
    chk("R8 m1_addr", 64'(m1_addr), 64'h00200010);
    chk("R8 m1_data", m1_data, 64'hA5A5_0000_1234_5678);
    @(negedge clk);
    req_addr = 32'hD0000000;
    #1;
    chk("R8 m0_valid", 64'(m0_valid), 64'd1);
    chk("R8 m1_valid off", 64'(m1_valid), 64'd0);
    chk("R8 ready from m0", 64'(req_ready), 64'd1);
    chk("R8 m0_data", m0_data, 64'hA5A5_0000_1234_5678);

    // R7 write takes effect after the edge
    @(negedge clk);
    req_addr = 32'h00000000;
    cfg_sel = 1'b1; cfg_we = 1'b1; cfg_addr = 12'hC00; cfg_wdata = 32'h00000001;
    #1 chk("R7 before edge", 64'(route_sel), 64'd0);
    @(negedge clk);
    cfg_sel = 1'b0; cfg_we = 1'b0;
    #1 chk("R7 after edge", 64'(route_sel), 64'd1);
    req_valid = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule